// File: doc/BRIEF.md
# Constant-fraction pulse timer

This block sits on a stream of unsigned digitizer samples and gives each detected pulse a timestamp that does not depend on pulse height. It first clips each sample by subtracting the sample taken a programmable number of samples earlier. The clipped pulse then drives the rest of the sequence. A leading-edge threshold arms the block. While armed, it tracks the peak and freezes it once the clipped signal has turned down. The frozen peak is scaled by a programmable fraction to give a crossing level. The block then scans a delayed copy of the clipped stream for the rising pair of samples that straddles that level.

The crossing point is found by linear interpolation between the two samples of that pair. A multi-cycle restoring divider computes it, and the block reports it as an 8-bit vernier together with the sample counter value of the lower sample. Each of the four runtime settings has its own input: the clip lag, the arming threshold, the fraction, and the comparison delay. When no straddling pair appears in the delayed window, the block pulses an error output in place of a timestamp. After any result it ignores new pulses until the clipped signal has dropped back to the threshold or below.

Top module: `cfd_timer`

## Requirements
- R1: The clipped value of an accepted sample is F[n] = x[n] - x[n-L], with L = clip_lag_i (1 to DEPTH-1), counted in accepted samples. Cycles with smp_valid_i low neither advance the history nor step the sequence.
- R2: From idle, the block arms only on a sample with F strictly greater than arm_thr_i. A clipped value equal to the threshold starts nothing.
- R3: While armed, the block keeps the running maximum of F, where a sample equal to the maximum counts as not below it. The peak is declared on the second consecutive sample below the maximum, or on the 64th sample after arming, whichever comes first.
- R4: The crossing level is floor(peak * frac_i / 256), with frac_i an unsigned fraction having 8 fractional bits.
- R5: Let D be cmp_lag_i. On each later sample n, the block tests the pair a = F[n-D-1], b = F[n-D]. The first pair with a <= level < b is taken, and ts_coarse_o equals smp_idx_i of sample n-D-1.
- R6: ts_fine_o = floor(256 * (level - a) / (b - a)). ts_valid_o is a one-cycle pulse in the ninth cycle after the clock edge that accepted sample n, and ts_coarse_o and ts_fine_o are valid while it is high.
- R7: Samples accepted during the division are ignored. After a timestamp or an error, arming resumes only after a sample with F <= arm_thr_i.
- R8: If D samples are tested without a matching pair, err_o pulses for one cycle after the edge that accepted the last tested sample, and no timestamp is produced.
- R9: While rst_ni is low, ts_valid_o and err_o are 0, the block is idle, and both histories read zero.
- R10: ts_valid_o and err_o are never high together, and ts_valid_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | DW | Unsigned sample |
| smp_idx_i | input | CW | Free-running sample counter value of this sample |
| clip_lag_i | input | LW | Clip lag L |
| arm_thr_i | input | DW | Arming threshold on the clipped signal |
| frac_i | input | FW | Constant fraction with 8 fractional bits |
| cmp_lag_i | input | LW | Comparison delay D |
| ts_valid_o | output | 1 | Timestamp strobe |
| ts_coarse_o | output | CW | Sample index of the lower sample of the pair |
| ts_fine_o | output | FW | Interpolated vernier |
| err_o | output | 1 | No crossing pair found |

## Verification
The assertions assume that the four settings stay fixed while a pulse is in flight, and that both lags are at least 1 and below DEPTH. The divider check also relies on the comparison delay being long enough that the pair it tests lies within the buffered history. The stimulus changes settings only after each run of baseline samples, with the block idle. It keeps L = 4 and D = 8, and it shapes its steps, fast pulses, slow ramps and very long ramps so that clipped values stay well inside the sample range.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SEEK,
    ST_DIVIDE,
    ST_REARM
  } cfd_state_e;
endpackage

// File: rtl/cfd_clip.sv
module cfd_clip #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [DW-1:0]        smp_i,
  input  logic [LW-1:0]        clip_lag_i,
  input  logic [LW-1:0]        cmp_lag_i,
  output logic signed [DW:0]   f_o,
  output logic signed [DW:0]   d_cur_o,
  output logic signed [DW:0]   d_prev_o
);
  logic [DW-1:0]      raw_q [DEPTH];
  logic signed [DW:0] fh_q  [DEPTH];
  logic [DW-1:0]      old_smp;

  // raw_q[0] holds the previous accepted sample
  assign old_smp  = raw_q[clip_lag_i - LW'(1)];
  assign f_o      = $signed({1'b0, smp_i}) - $signed({1'b0, old_smp});
  assign d_cur_o  = fh_q[cmp_lag_i - LW'(1)];
  assign d_prev_o = fh_q[cmp_lag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q[0] <= '0;
      fh_q[0]  <= '0;
    end else if (vld_i) begin
      raw_q[0] <= smp_i;
      fh_q[0]  <= f_o;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q[g] <= '0;
        fh_q[g]  <= '0;
      end else if (vld_i) begin
        raw_q[g] <= raw_q[g-1];
        fh_q[g]  <= fh_q[g-1];
      end
    end
  end
endmodule

// File: rtl/cfd_div.sv
module cfd_div #(
  parameter int NW   = 14,
  parameter int QW   = 8,
  parameter int CNTW = $clog2(QW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] q_o
);
  logic [NW:0]     rem_q, rem2, rem_sub;
  logic [NW-1:0]   den_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q, ge;

  assign rem2    = {rem_q[NW-1:0], 1'b0};
  assign ge      = rem2 >= {1'b0, den_q};
  assign rem_sub = rem2 - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      q_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        cnt_q  <= '0;
        q_o    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sub : rem2;
        q_o   <= {q_o[QW-2:0], ge};
        cnt_q <= cnt_q + CNTW'(1);
        if (cnt_q == CNTW'(QW-1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R6
  rem_below_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < {1'b0, den_q});
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
  import cfd_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int DEPTH = 16,
  parameter int FW    = 8,
  parameter int TMO   = 64,
  localparam int LW   = $clog2(DEPTH),
  localparam int TW   = $clog2(TMO),
  localparam int NW   = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic [CW-1:0] smp_idx_i,
  input  logic [LW-1:0] clip_lag_i,
  input  logic [DW-1:0] arm_thr_i,
  input  logic [FW-1:0] frac_i,
  input  logic [LW-1:0] cmp_lag_i,
  output logic          ts_valid_o,
  output logic [CW-1:0] ts_coarse_o,
  output logic [FW-1:0] ts_fine_o,
  output logic          err_o
);
  cfd_state_e         state_q;
  logic signed [DW:0] f_now, d_cur, d_prev, thr_s;
  logic signed [DW:0] max_q, level_q, nmax, lvl_new;
  logic [1:0]         below_q, nbelow;
  logic [TW-1:0]      tmo_q;
  logic [LW-1:0]      seek_q;
  logic [CW-1:0]      k_q;
  logic [DW+FW-1:0]   prod;
  logic signed [DW+1:0] num_s, den_s;
  logic               ge, bracket, div_start, div_done;

  cfd_clip #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_clip (
    .clk_i, .rst_ni, .vld_i(smp_valid_i), .smp_i, .clip_lag_i, .cmp_lag_i,
    .f_o(f_now), .d_cur_o(d_cur), .d_prev_o(d_prev)
  );

  assign thr_s   = $signed({1'b0, arm_thr_i});
  assign ge      = f_now >= max_q;
  assign nmax    = ge ? f_now : max_q;
  assign nbelow  = ge ? 2'd0 : below_q + 2'd1;
  assign prod    = nmax[DW-1:0] * frac_i;
  assign lvl_new = $signed({1'b0, prod[DW+FW-1:FW]});
  assign bracket = (d_prev <= level_q) && (d_cur > level_q);
  assign num_s   = {level_q[DW], level_q} - {d_prev[DW], d_prev};
  assign den_s   = {d_cur[DW], d_cur} - {d_prev[DW], d_prev};
  assign div_start = (state_q == ST_SEEK) && smp_valid_i && bracket;

  cfd_div #(.NW(NW), .QW(FW)) u_div (
    .clk_i, .rst_ni, .start_i(div_start),
    .num_i($unsigned(num_s)), .den_i($unsigned(den_s)),
    .done_o(div_done), .q_o(ts_fine_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      max_q   <= '0;
      level_q <= '0;
      below_q <= '0;
      tmo_q   <= '0;
      seek_q  <= '0;
      k_q     <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (smp_valid_i && f_now > thr_s) begin
          state_q <= ST_ARMED;
          max_q   <= f_now;
          below_q <= '0;
          tmo_q   <= '0;
        end
        ST_ARMED: if (smp_valid_i) begin
          max_q   <= nmax;
          below_q <= nbelow;
          if (nbelow == 2'd2 || tmo_q == TW'(TMO-1)) begin
            level_q <= lvl_new;
            seek_q  <= '0;
            state_q <= ST_SEEK;
          end else begin
            tmo_q <= tmo_q + TW'(1);
          end
        end
        ST_SEEK: if (smp_valid_i) begin
          if (bracket) begin
            k_q     <= smp_idx_i - CW'(cmp_lag_i) - CW'(1);
            state_q <= ST_DIVIDE;
          end else if (seek_q == cmp_lag_i - LW'(1)) begin
            err_o   <= 1'b1;
            state_q <= ST_REARM;
          end else begin
            seek_q <= seek_q + LW'(1);
          end
        end
        ST_DIVIDE: if (div_done) state_q <= ST_REARM;
        ST_REARM: if (smp_valid_i && f_now <= thr_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ts_valid_o  = div_done;
  assign ts_coarse_o = k_q;

  // R2
  arm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && $past(state_q) == ST_IDLE)
      |-> ($past(smp_valid_i) && $past(f_now) > $past(thr_s)));
  // R4
  level_le_peak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEEK) |-> level_q <= max_q);
  // R8
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(state_q) == ST_SEEK);
  // R10
  out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ts_valid_o && err_o));
  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |=> !ts_valid_o);
endmodule

// File: tb/sim_cfd_timer.sv
module sim_cfd_timer;
  localparam int DW = 12, CW = 16, DEPTH = 16, FW = 8;
  localparam int L = 4, D = 8, THR = 50;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [DW-1:0] smp = '0;
  logic [CW-1:0] idx = '0;
  logic [FW-1:0] frac = 8'd128;
  logic tsv, err;
  logic [CW-1:0] crs;
  logic [FW-1:0] fine;

  int checks = 0, errors = 0, cyc = 0, idx_cnt = 0;
  int ts_n = 0, err_n = 0, last_fine = 0, last_crs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfd_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .smp_i(smp), .smp_idx_i(idx),
    .clip_lag_i(4'(L)), .arm_thr_i(12'(THR)), .frac_i(frac), .cmp_lag_i(4'(D)),
    .ts_valid_o(tsv), .ts_coarse_o(crs), .ts_fine_o(fine), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_raw[DEPTH], m_fh[DEPTH];
  int m_st, m_mx, m_bl, m_tmo, m_lvl, m_sk, m_k, m_q, m_dl;
  bit e_tsv, e_err;
  int e_fine, e_crs;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_raw[i]) begin m_raw[i] = 0; m_fh[i] = 0; end
      m_st = 0; m_mx = 0; m_bl = 0; m_tmo = 0; m_lvl = 0; m_sk = 0; m_dl = 0;
      e_tsv = 0; e_err = 0;
    end else begin
      int st0, f, dc, dp;
      st0 = m_st;
      e_tsv = 0; e_err = 0;
      if (st0 == 3) begin
        if (m_dl > 0) begin
          m_dl--;
          if (m_dl == 0) begin e_tsv = 1; e_fine = m_q; e_crs = m_k; end
        end else m_st = 4;
      end
      if (vld) begin
        f = int'(smp) - m_raw[L-1];
        dc = m_fh[D-1];
        dp = m_fh[D];
        case (st0)
          0: if (f > THR) begin m_st = 1; m_mx = f; m_bl = 0; m_tmo = 0; end
          1: begin
            if (f >= m_mx) begin m_mx = f; m_bl = 0; end else m_bl++;
            if (m_bl == 2 || m_tmo == 63) begin
              m_lvl = (m_mx * int'(frac)) / 256; m_st = 2; m_sk = 0;
            end else m_tmo++;
          end
          2: begin
            if (dp <= m_lvl && dc > m_lvl) begin
              m_k = (int'(idx) - D - 1) & 16'hFFFF;
              m_q = ((m_lvl - dp) * 256) / (dc - dp);
              m_dl = 8; m_st = 3;
            end else if (m_sk == D - 1) begin e_err = 1; m_st = 4; end
            else m_sk++;
          end
          4: if (f <= THR) m_st = 0;
          default: ;
        endcase
        for (int i = DEPTH - 1; i > 0; i--) begin m_raw[i] = m_raw[i-1]; m_fh[i] = m_fh[i-1]; end
        m_raw[0] = int'(smp);
        m_fh[0] = f;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(tsv == e_tsv, "R6 ts_valid", int'(tsv), int'(e_tsv));
      check(err == e_err, "R8 err", int'(err), int'(e_err));
      check(!(tsv && err), "R10 exclusive", int'(tsv) + int'(err), 1);
      if (e_tsv) begin
        check(int'(crs) == e_crs, "R5 coarse", int'(crs), e_crs);
        check(int'(fine) == e_fine, "R6 fine", int'(fine), e_fine);
      end
      if (tsv) begin ts_n++; last_fine = int'(fine); last_crs = int'(crs); end
      if (err) err_n++;
    end
  end

  task automatic send(input int v);
    @(negedge clk);
    vld = 1'b1; smp = DW'(v); idx = CW'(idx_cnt);
    idx_cnt++;
  endtask

  task automatic gap();
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic hold(input int v, input int n);
    for (int i = 0; i < n; i++) send(v);
  endtask

  task automatic pulse(input int amp, input int rise, input bit gaps);
    int v;
    for (int i = 1; i <= rise; i++) begin
      send(amp * i / rise);
      if (gaps) gap();
    end
    v = amp;
    for (int i = 0; i < 40; i++) begin
      v = v - (v >>> 3);
      send(v);
      if (gaps) gap();
    end
    hold(0, 12);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int s, t0, e0;
    repeat (4) @(negedge clk);
    // R9
    check(tsv == 1'b0 && err == 1'b0, "R9 reset outputs", int'(tsv) + int'(err), 0);
    rst_n = 1'b1;
    hold(0, 20);

    // R2: clipped value equal to threshold never arms
    t0 = ts_n; e0 = err_n;
    hold(THR, 30); hold(0, 20);
    check(ts_n == t0 && err_n == e0, "R2 equal threshold", ts_n - t0, 0);

    // R5/R6: step of THR+1, half fraction
    t0 = ts_n;
    s = idx_cnt;
    hold(THR + 1, 30); hold(0, 20);
    check(ts_n == t0 + 1, "R6 step count", ts_n - t0, 1);
    check(last_fine == 125, "R6 step vernier", last_fine, 125);
    check(last_crs == s - 1, "R5 step coarse", last_crs, s - 1);

    // R4: other fraction
    frac = 8'd200;
    t0 = ts_n;
    hold(THR + 1, 30); hold(0, 20);
    check(ts_n == t0 + 1, "R4 count", ts_n - t0, 1);
    check(last_fine == 195, "R4 vernier", last_fine, 195);

    // R3/R5: fast pulses of varied height
    frac = 8'd128;
    t0 = ts_n;
    pulse(2000, 3, 1'b0);
    pulse(900, 2, 1'b0);
    pulse(3500, 3, 1'b0);
    check(ts_n == t0 + 3, "R3 pulse count", ts_n - t0, 3);

    // R1: pulses with invalid cycles between samples
    frac = 8'd77;
    t0 = ts_n;
    pulse(1500, 3, 1'b1);
    pulse(2600, 2, 1'b1);
    check(ts_n == t0 + 2, "R1 gapped pulses", ts_n - t0, 2);

    // R7: second rise during division and rearm hold
    frac = 8'd128;
    t0 = ts_n;
    hold(THR + 1, 16); hold(400, 10); hold(0, 20);
    check(ts_n == t0 + 1, "R7 retrigger ignored", ts_n - t0, 1);

    // R8: slow rise, crossing left the delayed window
    t0 = ts_n; e0 = err_n;
    for (int i = 1; i <= 30; i++) send(80 * i);
    hold(2400, 20); hold(0, 20);
    check(err_n == e0 + 1 && ts_n == t0, "R8 slow rise error", err_n - e0, 1);

    // R3: timeout on very long rise
    t0 = ts_n; e0 = err_n;
    for (int i = 1; i <= 100; i++) send(20 * i);
    hold(2000, 20); hold(0, 20);
    check(err_n == e0 + 1 && ts_n == t0, "R3 timeout", err_n - e0, 1);

    gap();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end
endmodule